// File: doc/BRIEF.md
# Software-Refilled Associative Translation Buffer

This block is a fully associative address translation buffer that never walks page tables itself. Every cycle it compares the page number of the address on its lookup port, together with the current address-space ID, against all stored entries. On a usable match it returns the physical address and the uncached attribute. Otherwise it classifies the fault: no match (refill), match on an invalid entry, or a store to a write-protected entry. It also chooses the exception vector. Unmatched user-segment addresses get the fast refill vector; every other fault gets the general vector.

Software maintains the buffer through four registers: a tag register (page number and address-space ID), a data register (frame number and attribute bits), an index register and a free-running victim counter. A small command sequencer carries out four commands: read an entry into the tag and data registers, probe for the entry matching the tag register, write the registers at the index, or write them at the victim slot. On every fault the block captures the faulting address, a cause code and the faulting page number. The refill handler then only has to fill the data register and issue a victim-slot write.

Top module: `soft_tlb`

## Requirements
- R1: An entry that has not been written since reset never matches. A written entry matches when its page number equals address bits [31:12] and either its global bit is set or its address-space ID equals the tag register's ID.
- R2: A lookup that matches a valid entry is a hit when it is a load, or when it is a store and the entry's dirty bit is set. On a hit, lk_hit=1, lk_fault=0, lk_paddr = {frame, vaddr[11:0]} and lk_uncached equals the entry's N bit.
- R3: A lookup with no match faults with cause 2 for a load or 3 for a store. The vector is 0x80000000 when vaddr[31]=0, and 0x80000080 otherwise.
- R4: A lookup that matches an entry with V=0 faults with cause 2 for a load or 3 for a store, using vector 0x80000080.
- R5: A store that matches a valid entry with D=0 faults with cause 1 (modify), using vector 0x80000080.
- R6: At the clock edge that ends a faulting lookup, the bad-address register takes vaddr, the cause register takes the cause code, and the tag register's page field takes vaddr[31:12]. The ID field is kept.
- R7: The register write port selects by sw_wr_sel: 0 writes the tag register (page bits [31:12], ID bits [5:0], other bits read 0); 1 writes the data register (frame bits [31:12], N bit 11, D bit 10, V bit 9, G bit 8, bits [7:0] read 0); 2 writes the index register (probe-fail bit 31, index in the low bits); 3 changes nothing. A tag-register write takes precedence over a fault capture in the same cycle, but the bad-address register is still captured.
- R8: The sequencer moves IDLE to EXEC on cmd_valid (ACCEPT), EXEC to DONE (COMMIT) and DONE to IDLE (RETIRE). cmd_busy is high in EXEC and DONE, and cmd_done is high in DONE. cmd_valid is ignored while busy.
- R9: Command 0 (read) loads the tag and data registers from the entry selected by the index register.
- R10: Command 1 (probe) searches for the tag register's page and ID. On a match the index register becomes {0, entry number}. With no match, bit 31 is set and the low bits are kept.
- R11: Command 2 writes the tag and data registers into the entry at the index register. Command 3 writes them at the entry named by the victim counter during EXEC.
- R12: The victim counter resets to ENTRIES-1, decrements every clock cycle, and wraps from 0 to ENTRIES-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_store | input | 1 | 1 for a store, 0 for a load |
| lk_hit | output | 1 | Translation succeeded |
| lk_paddr | output | PFN_W+12 | Physical address on a hit |
| lk_uncached | output | 1 | N bit of the hit entry |
| lk_fault | output | 1 | Lookup faulted |
| lk_cause | output | 2 | Fault cause: 1 modify, 2 load, 3 store |
| lk_vector | output | 32 | Exception vector for the fault |
| sw_wr_en | input | 1 | Register write strobe |
| sw_wr_sel | input | 2 | Register select |
| sw_wr_data | input | 32 | Register write data |
| cmd_valid | input | 1 | Start a command |
| cmd_op | input | 2 | 0 read, 1 probe, 2 indexed write, 3 victim write |
| cmd_busy | output | 1 | Command in progress |
| cmd_done | output | 1 | Command completed this cycle |
| entryhi_q | output | 32 | Tag register word |
| entrylo_q | output | 32 | Data register word |
| index_q | output | 32 | Index register word |
| random_q | output | log2(ENTRIES) | Victim counter |
| badvaddr_q | output | 32 | Last faulting address |
| cause_q | output | 2 | Last fault cause |

## Verification
The bench builds the block with ENTRIES=8 and the default 6-bit ID and 20-bit frame. This lets it fill, read back and probe every slot. It also sweeps every slot with both loads and stores, under the owning ID and a foreign ID. With eight slots the victim counter wraps every eight cycles, so its sequence and the slot chosen by a victim write can be predicted arithmetically from the cycle count since reset.

// File: rtl/soft_tlb_pkg.sv
package soft_tlb_pkg;

    localparam int VADDR_W    = 32;
    localparam int PAGE_SHIFT = 12;

    typedef enum logic [1:0] {
        OP_READ       = 2'd0,
        OP_PROBE      = 2'd1,
        OP_WRITE_IDX  = 2'd2,
        OP_WRITE_RAND = 2'd3
    } tlb_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EXEC = 2'd1,
        ST_DONE = 2'd2
    } cmd_state_e;

    typedef enum logic [1:0] {
        SEL_HI    = 2'd0,
        SEL_LO    = 2'd1,
        SEL_INDEX = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'd0,
        CAUSE_MODIFY = 2'd1,
        CAUSE_LOAD   = 2'd2,
        CAUSE_STORE  = 2'd3
    } cause_e;

    localparam logic [31:0] REFILL_VECTOR  = 32'h8000_0000;
    localparam logic [31:0] GENERAL_VECTOR = 32'h8000_0080;

endpackage

// File: rtl/tlb_victim_counter.sv
module tlb_victim_counter #(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [IDX_W-1:0] value
);
    localparam logic [IDX_W-1:0] TOP = IDX_W'(ENTRIES - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value <= TOP;
        end else if (value == '0) begin
            value <= TOP;
        end else begin
            value <= value - 1'b1;
        end
    end

    assert_wrap_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (value == '0) |=> (value == TOP));
    assert_step_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (value != '0) |=> (value == $past(value) - 1'b1));

endmodule

// File: rtl/tlb_cmd_fsm.sv
module tlb_cmd_fsm
    import soft_tlb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_op,
    output logic       busy,
    output logic       done,
    output logic       do_read,
    output logic       do_probe,
    output logic       do_write_idx,
    output logic       do_write_rand
);
    cmd_state_e state_q, state_d;
    tlb_op_e    op_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // command latched on ACCEPT
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q <= OP_READ;
        end else if (state_q == ST_IDLE && cmd_valid) begin
            op_q <= tlb_op_e'(cmd_op);
        end
    end

    // transitions: ACCEPT, COMMIT, RETIRE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cmd_valid) state_d = ST_EXEC;
            ST_EXEC: state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy          = 1'b0;
        done          = 1'b0;
        do_read       = 1'b0;
        do_probe      = 1'b0;
        do_write_idx  = 1'b0;
        do_write_rand = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_EXEC: begin
                busy          = 1'b1;
                do_read       = (op_q == OP_READ);
                do_probe      = (op_q == OP_PROBE);
                do_write_idx  = (op_q == OP_WRITE_IDX);
                do_write_rand = (op_q == OP_WRITE_RAND);
            end
            ST_DONE: begin
                busy = 1'b1;
                done = 1'b1;
            end
            default: ;
        endcase
    end

    assert_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_valid) |=> (busy && !done));
    assert_retire_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    assert_one_action_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({do_read, do_probe, do_write_idx, do_write_rand}));

endmodule

// File: rtl/tlb_entry_array.sv
module tlb_entry_array #(
    parameter int ENTRIES = 64,
    parameter int VPN_W   = 20,
    parameter int ASID_W  = 6,
    parameter int PFN_W   = 20,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    // write port
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic [PFN_W-1:0]  wr_pfn,
    input  logic [3:0]        wr_flags,   // {n, d, v, g}
    // read port
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [VPN_W-1:0]  rd_vpn,
    output logic [ASID_W-1:0] rd_asid,
    output logic [PFN_W-1:0]  rd_pfn,
    output logic [3:0]        rd_flags,
    // translation search
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              lk_match,
    output logic [PFN_W-1:0]  lk_pfn,
    output logic [3:0]        lk_flags,
    // probe search
    input  logic [VPN_W-1:0]  pb_vpn,
    input  logic [ASID_W-1:0] pb_asid,
    output logic              pb_match,
    output logic [IDX_W-1:0]  pb_idx
);
    localparam int FLAG_G = 0;

    logic [VPN_W-1:0]  e_vpn   [ENTRIES];
    logic [ASID_W-1:0] e_asid  [ENTRIES];
    logic [PFN_W-1:0]  e_pfn   [ENTRIES];
    logic [3:0]        e_flags [ENTRIES];
    logic [ENTRIES-1:0] e_used;

    logic [ENTRIES-1:0] lk_vec;
    logic [ENTRIES-1:0] pb_vec;
    logic [IDX_W-1:0]   lk_idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                e_vpn[i]   <= '0;
                e_asid[i]  <= '0;
                e_pfn[i]   <= '0;
                e_flags[i] <= '0;
            end
            e_used <= '0;
        end else if (wr_en) begin
            e_vpn[wr_idx]   <= wr_vpn;
            e_asid[wr_idx]  <= wr_asid;
            e_pfn[wr_idx]   <= wr_pfn;
            e_flags[wr_idx] <= wr_flags;
            e_used[wr_idx]  <= 1'b1;
        end
    end

    // one comparator pair per entry
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        logic asid_free;
        assign asid_free = e_flags[g][FLAG_G];
        assign lk_vec[g] = e_used[g] && (e_vpn[g] == lk_vpn) &&
                           (asid_free || (e_asid[g] == lk_asid));
        assign pb_vec[g] = e_used[g] && (e_vpn[g] == pb_vpn) &&
                           (asid_free || (e_asid[g] == pb_asid));
    end

    always_comb begin
        lk_idx = '0;
        pb_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (lk_vec[i]) lk_idx = IDX_W'(i);
            if (pb_vec[i]) pb_idx = IDX_W'(i);
        end
    end

    assign lk_match = |lk_vec;
    assign pb_match = |pb_vec;
    assign lk_pfn   = e_pfn[lk_idx];
    assign lk_flags = e_flags[lk_idx];

    assign rd_vpn   = e_vpn[rd_idx];
    assign rd_asid  = e_asid[rd_idx];
    assign rd_pfn   = e_pfn[rd_idx];
    assign rd_flags = e_flags[rd_idx];

    assert_single_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_vec));
    assert_write_lands_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (e_vpn[$past(wr_idx)] == $past(wr_vpn)) && e_used[$past(wr_idx)]);

endmodule

// File: rtl/soft_tlb.sv
module soft_tlb
    import soft_tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int ASID_W  = 6,
    parameter int PFN_W   = 20,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int VPN_W  = VADDR_W - PAGE_SHIFT,
    localparam int PA_W   = PFN_W + PAGE_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [31:0]       lk_vaddr,
    input  logic              lk_store,
    output logic              lk_hit,
    output logic [PA_W-1:0]   lk_paddr,
    output logic              lk_uncached,
    output logic              lk_fault,
    output logic [1:0]        lk_cause,
    output logic [31:0]       lk_vector,
    input  logic              sw_wr_en,
    input  logic [1:0]        sw_wr_sel,
    input  logic [31:0]       sw_wr_data,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    output logic              cmd_busy,
    output logic              cmd_done,
    output logic [31:0]       entryhi_q,
    output logic [31:0]       entrylo_q,
    output logic [31:0]       index_q,
    output logic [IDX_W-1:0]  random_q,
    output logic [31:0]       badvaddr_q,
    output logic [1:0]        cause_q
);
    localparam int F_N = 3;
    localparam int F_D = 2;
    localparam int F_V = 1;

    // software-visible state
    logic [VPN_W-1:0]  hi_vpn;
    logic [ASID_W-1:0] hi_asid;
    logic [PFN_W-1:0]  lo_pfn;
    logic [3:0]        lo_flags;
    logic [IDX_W-1:0]  idx_val;
    logic              idx_fail;
    logic [31:0]       bad_addr;
    cause_e            cause_r;

    // sequencer strobes
    logic do_read, do_probe, do_write_idx, do_write_rand;

    // array signals
    logic [VPN_W-1:0]  rd_vpn;
    logic [ASID_W-1:0] rd_asid;
    logic [PFN_W-1:0]  rd_pfn;
    logic [3:0]        rd_flags;
    logic              arr_match;
    logic [PFN_W-1:0]  arr_pfn;
    logic [3:0]        arr_flags;
    logic              pb_match;
    logic [IDX_W-1:0]  pb_idx;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [IDX_W-1:0]  victim;

    // lookup classification
    cause_e            fault_cause;
    logic              fault_now;
    logic              sw_hi, sw_lo, sw_idx;
    logic              unused_sw;

    tlb_cmd_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_valid     (cmd_valid),
        .cmd_op        (cmd_op),
        .busy          (cmd_busy),
        .done          (cmd_done),
        .do_read       (do_read),
        .do_probe      (do_probe),
        .do_write_idx  (do_write_idx),
        .do_write_rand (do_write_rand)
    );

    tlb_victim_counter #(.ENTRIES(ENTRIES)) u_victim (
        .clk   (clk),
        .rst_n (rst_n),
        .value (victim)
    );

    assign wr_en  = do_write_idx | do_write_rand;
    assign wr_idx = do_write_rand ? victim : idx_val;

    tlb_entry_array #(
        .ENTRIES (ENTRIES),
        .VPN_W   (VPN_W),
        .ASID_W  (ASID_W),
        .PFN_W   (PFN_W)
    ) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_vpn   (hi_vpn),
        .wr_asid  (hi_asid),
        .wr_pfn   (lo_pfn),
        .wr_flags (lo_flags),
        .rd_idx   (idx_val),
        .rd_vpn   (rd_vpn),
        .rd_asid  (rd_asid),
        .rd_pfn   (rd_pfn),
        .rd_flags (rd_flags),
        .lk_vpn   (lk_vaddr[31:PAGE_SHIFT]),
        .lk_asid  (hi_asid),
        .lk_match (arr_match),
        .lk_pfn   (arr_pfn),
        .lk_flags (arr_flags),
        .pb_vpn   (hi_vpn),
        .pb_asid  (hi_asid),
        .pb_match (pb_match),
        .pb_idx   (pb_idx)
    );

    // fault classification and vector selection
    always_comb begin
        lk_hit      = 1'b0;
        lk_fault    = 1'b0;
        fault_cause = CAUSE_NONE;
        lk_vector   = '0;
        if (lk_valid) begin
            if (!arr_match) begin
                lk_fault    = 1'b1;
                fault_cause = lk_store ? CAUSE_STORE : CAUSE_LOAD;
                lk_vector   = lk_vaddr[31] ? GENERAL_VECTOR : REFILL_VECTOR;
            end else if (!arr_flags[F_V]) begin
                lk_fault    = 1'b1;
                fault_cause = lk_store ? CAUSE_STORE : CAUSE_LOAD;
                lk_vector   = GENERAL_VECTOR;
            end else if (lk_store && !arr_flags[F_D]) begin
                lk_fault    = 1'b1;
                fault_cause = CAUSE_MODIFY;
                lk_vector   = GENERAL_VECTOR;
            end else begin
                lk_hit = 1'b1;
            end
        end
    end

    assign fault_now   = lk_fault;
    assign lk_cause    = fault_cause;
    assign lk_paddr    = lk_hit ? {arr_pfn, lk_vaddr[PAGE_SHIFT-1:0]} : '0;
    assign lk_uncached = lk_hit & arr_flags[F_N];

    assign sw_hi  = sw_wr_en && (reg_sel_e'(sw_wr_sel) == SEL_HI);
    assign sw_lo  = sw_wr_en && (reg_sel_e'(sw_wr_sel) == SEL_LO);
    assign sw_idx = sw_wr_en && (reg_sel_e'(sw_wr_sel) == SEL_INDEX);
    assign unused_sw = ^sw_wr_data;

    // tag register: command read > software write > fault capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_vpn  <= '0;
            hi_asid <= '0;
        end else if (do_read) begin
            hi_vpn  <= rd_vpn;
            hi_asid <= rd_asid;
        end else if (sw_hi) begin
            hi_vpn  <= sw_wr_data[31:PAGE_SHIFT];
            hi_asid <= sw_wr_data[ASID_W-1:0];
        end else if (fault_now) begin
            hi_vpn  <= lk_vaddr[31:PAGE_SHIFT];
        end
    end

    // data register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_pfn   <= '0;
            lo_flags <= '0;
        end else if (do_read) begin
            lo_pfn   <= rd_pfn;
            lo_flags <= rd_flags;
        end else if (sw_lo) begin
            lo_pfn   <= sw_wr_data[PAGE_SHIFT +: PFN_W];
            lo_flags <= sw_wr_data[11:8];
        end
    end

    // index register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_val  <= '0;
            idx_fail <= 1'b0;
        end else if (do_probe) begin
            idx_fail <= !pb_match;
            if (pb_match) idx_val <= pb_idx;
        end else if (sw_idx) begin
            idx_val  <= sw_wr_data[IDX_W-1:0];
            idx_fail <= sw_wr_data[31];
        end
    end

    // fault capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bad_addr <= '0;
            cause_r  <= CAUSE_NONE;
        end else if (fault_now) begin
            bad_addr <= lk_vaddr;
            cause_r  <= fault_cause;
        end
    end

    assign entryhi_q  = (32'(hi_vpn) << PAGE_SHIFT) | 32'(hi_asid);
    assign entrylo_q  = (32'(lo_pfn) << PAGE_SHIFT) | (32'(lo_flags) << 8);
    assign index_q    = (32'(idx_fail) << 31) | 32'(idx_val);
    assign random_q   = victim;
    assign badvaddr_q = bad_addr;
    assign cause_q    = cause_r;

    assert_hit_excludes_fault_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_hit && lk_fault));
    assert_refill_user_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_fault && lk_vector == REFILL_VECTOR) |-> (!lk_vaddr[31] && !arr_match));
    assert_modify_on_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_fault && lk_cause == 2'd1) |-> (lk_store && arr_match));
    assert_capture_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_fault) |=> (badvaddr_q == $past(lk_vaddr)));
    assert_capture_page_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_fault && !do_read && !sw_hi) |=> (entryhi_q[31:12] == $past(lk_vaddr[31:12])));
    assert_probe_miss_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (do_probe && !pb_match) |=> (index_q[31] && $stable(index_q[IDX_W-1:0])));

endmodule

// File: tb/sim_soft_tlb.sv
module sim_soft_tlb;
    localparam int ENT = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        lk_store = 1'b0;
    logic        lk_hit, lk_uncached, lk_fault;
    logic [31:0] lk_paddr;
    logic [1:0]  lk_cause;
    logic [31:0] lk_vector;
    logic        sw_wr_en = 1'b0;
    logic [1:0]  sw_wr_sel = '0;
    logic [31:0] sw_wr_data = '0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic        cmd_busy, cmd_done;
    logic [31:0] entryhi_q, entrylo_q, index_q, badvaddr_q;
    logic [2:0]  random_q;
    logic [1:0]  cause_q;

    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;

    // bench model of entry contents
    logic [19:0] m_vpn  [ENT];
    logic [5:0]  m_asid [ENT];
    logic [19:0] m_pfn  [ENT];
    logic [3:0]  m_flg  [ENT];   // {n, d, v, g}
    logic [ENT-1:0] m_used = '0;
    logic [5:0]  cur_asid = '0;
    logic [31:0] last_bad = '0;

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    soft_tlb #(.ENTRIES(ENT)) u0 (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_store(lk_store),
        .lk_hit(lk_hit), .lk_paddr(lk_paddr), .lk_uncached(lk_uncached),
        .lk_fault(lk_fault), .lk_cause(lk_cause), .lk_vector(lk_vector),
        .sw_wr_en(sw_wr_en), .sw_wr_sel(sw_wr_sel), .sw_wr_data(sw_wr_data),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_busy(cmd_busy), .cmd_done(cmd_done),
        .entryhi_q(entryhi_q), .entrylo_q(entrylo_q), .index_q(index_q),
        .random_q(random_q), .badvaddr_q(badvaddr_q), .cause_q(cause_q)
    );

    function automatic logic [31:0] hi_word(input logic [19:0] vpn, input logic [5:0] asid);
        return {vpn, 6'b0, asid};
    endfunction

    function automatic logic [31:0] lo_word(input logic [19:0] pfn, input logic [3:0] flg);
        return {pfn, flg, 8'h00};
    endfunction

    function automatic logic [2:0] exp_rand();
        return 3'((ENT - 1) - (cyc % ENT));
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic sw_wr(input logic [1:0] sel, input logic [31:0] d);
        sw_wr_en = 1'b1; sw_wr_sel = sel; sw_wr_data = d;
        @(negedge clk);
        sw_wr_en = 1'b0;
        if (sel == 2'd0) cur_asid = d[5:0];
    endtask

    task automatic run_cmd(input logic [1:0] op, output logic [2:0] slot);
        cmd_valid = 1'b1; cmd_op = op;
        @(negedge clk);
        cmd_valid = 1'b0;
        slot = exp_rand();
        check("R8 exec busy", {31'b0, cmd_busy}, 32'd1);
        check("R8 exec not done", {31'b0, cmd_done}, 32'd0);
        @(negedge clk);
        check("R8 done", {31'b0, cmd_done}, 32'd1);
        @(negedge clk);
        check("R8 idle", {31'b0, cmd_busy}, 32'd0);
    endtask

    task automatic lookup(input logic [31:0] va, input logic st);
        logic hit_e, fault_e;
        logic [1:0] cause_e;
        logic [31:0] vec_e, pa_e;
        logic unc_e;
        int j;
        j = -1;
        for (int k = 0; k < ENT; k++)
            if (m_used[k] && m_vpn[k] == va[31:12] && (m_flg[k][0] || m_asid[k] == cur_asid))
                j = k;
        hit_e = 0; fault_e = 1; pa_e = 0; unc_e = 0; vec_e = 32'h8000_0080;
        if (j < 0) begin
            cause_e = st ? 2'd3 : 2'd2;
            vec_e = va[31] ? 32'h8000_0080 : 32'h8000_0000;
        end else if (!m_flg[j][1]) begin
            cause_e = st ? 2'd3 : 2'd2;
        end else if (st && !m_flg[j][2]) begin
            cause_e = 2'd1;
        end else begin
            hit_e = 1; fault_e = 0; cause_e = 2'd0;
            pa_e = {m_pfn[j], va[11:0]}; unc_e = m_flg[j][3];
        end
        lk_valid = 1'b1; lk_vaddr = va; lk_store = st;
        #1;
        check("R1/R2 hit", {31'b0, lk_hit}, {31'b0, hit_e});
        check("R3/R4/R5 fault", {31'b0, lk_fault}, {31'b0, fault_e});
        if (fault_e) begin
            check("R3/R4/R5 cause", {30'b0, lk_cause}, {30'b0, cause_e});
            check("R3/R4/R5 vector", lk_vector, vec_e);
        end else begin
            check("R2 paddr", lk_paddr, pa_e);
            check("R2 uncached", {31'b0, lk_uncached}, {31'b0, unc_e});
        end
        @(negedge clk);
        lk_valid = 1'b0;
        if (fault_e) begin
            last_bad = va;
            check("R6 badvaddr", badvaddr_q, va);
            check("R6 cause_q", {30'b0, cause_q}, {30'b0, cause_e});
            check("R6 entryhi page", entryhi_q, hi_word(va[31:12], cur_asid));
        end else begin
            check("R6 badvaddr kept", badvaddr_q, last_bad);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [2:0] slot;
        logic [31:0] h0, l0, x0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // reset state
        check("R8 reset busy", {31'b0, cmd_busy}, 32'd0);
        check("R7 reset entryhi", entryhi_q, 32'd0);
        check("R7 reset index", index_q, 32'd0);
        check("R12 reset-relative random", {29'b0, random_q}, {29'b0, exp_rand()});
        // R1: empty array never matches
        lookup(32'h0000_0000, 1'b0);

        // R12 counter sweep across wraps
        for (int k = 0; k < 20; k++) begin
            check("R12 random", {29'b0, random_q}, {29'b0, exp_rand()});
            @(negedge clk);
        end

        // R7 field masks and ignored select
        sw_wr(2'd0, 32'hFFFF_FFFF);
        check("R7 entryhi mask", entryhi_q, 32'hFFFF_F03F);
        sw_wr(2'd1, 32'hFFFF_FFFF);
        check("R7 entrylo mask", entrylo_q, 32'hFFFF_FF00);
        sw_wr(2'd2, 32'hFFFF_FFFF);
        check("R7 index mask", index_q, 32'h8000_0007);
        h0 = entryhi_q; l0 = entrylo_q; x0 = index_q;
        sw_wr(2'd3, 32'h1234_5678);
        check("R7 sel3 hi", entryhi_q, h0);
        check("R7 sel3 lo", entrylo_q, l0);
        check("R7 sel3 index", index_q, x0);

        // R11 fill every slot with indexed writes
        for (int i = 0; i < ENT; i++) begin
            m_vpn[i]  = (i == 7) ? 20'h80007 : 20'h00100 + 20'(i);
            m_asid[i] = 6'(i + 1);
            m_pfn[i]  = 20'h40000 + 20'(i * 3);
            m_flg[i]  = {(i == 6), (i != 3), (i != 5), (i == 2)};
            sw_wr(2'd0, hi_word(m_vpn[i], m_asid[i]));
            sw_wr(2'd1, lo_word(m_pfn[i], m_flg[i]));
            sw_wr(2'd2, 32'(i));
            run_cmd(2'd2, slot);
            m_used[i] = 1'b1;
        end

        // R9 read back each slot
        for (int i = 0; i < ENT; i++) begin
            sw_wr(2'd0, 32'd0);
            sw_wr(2'd1, 32'd0);
            sw_wr(2'd2, 32'(i));
            run_cmd(2'd0, slot);
            check("R9 read entryhi", entryhi_q, hi_word(m_vpn[i], m_asid[i]));
            check("R9 read entrylo", entrylo_q, lo_word(m_pfn[i], m_flg[i]));
        end

        // R10 probe each slot, a global entry, and a miss
        for (int i = 0; i < ENT; i++) begin
            sw_wr(2'd2, 32'((i + 3) % ENT));
            sw_wr(2'd0, hi_word(m_vpn[i], m_asid[i]));
            run_cmd(2'd1, slot);
            check("R10 probe hit", index_q, 32'(i));
        end
        sw_wr(2'd0, hi_word(m_vpn[2], 6'h3F));
        run_cmd(2'd1, slot);
        check("R10 probe global", index_q, 32'd2);
        sw_wr(2'd2, 32'd3);
        sw_wr(2'd0, hi_word(20'h55555, 6'd1));
        run_cmd(2'd1, slot);
        check("R10 probe miss", index_q, 32'h8000_0003);

        // R1-R6 lookup sweep: every slot, own and foreign ID, load and store
        for (int i = 0; i < ENT; i++) begin
            for (int a = 0; a < 2; a++) begin
                for (int s = 0; s < 2; s++) begin
                    sw_wr(2'd0, hi_word(20'h0, (a == 0) ? m_asid[i] : 6'h3F));
                    lookup({m_vpn[i], 12'h5A4}, s[0]);
                end
            end
        end
        sw_wr(2'd0, hi_word(20'h0, 6'd1));
        lookup(32'h1234_5678, 1'b0);   // R3 user miss, load
        lookup(32'h1234_5678, 1'b1);   // R3 user miss, store
        lookup(32'hC000_0010, 1'b0);   // R3 kernel miss
        lookup(32'hC000_0010, 1'b1);

        // R11 victim writes land on the predicted slot
        for (int k = 0; k < 2; k++) begin
            sw_wr(2'd0, hi_word(20'h2AAA0 + 20'(k), 6'd1));
            sw_wr(2'd1, lo_word(20'h0BEE0 + 20'(k), 4'b0110));
            run_cmd(2'd3, slot);
            m_vpn[slot] = 20'h2AAA0 + 20'(k);
            m_asid[slot] = 6'd1;
            m_pfn[slot] = 20'h0BEE0 + 20'(k);
            m_flg[slot] = 4'b0110;
            run_cmd(2'd1, x0[2:0]);
            check("R11 victim slot", index_q, {29'b0, slot});
            lookup({20'h2AAA0 + 20'(k), 12'h010}, 1'b1);
        end

        // R7 software tag write wins over fault capture in the same cycle
        sw_wr_en = 1'b1; sw_wr_sel = 2'd0; sw_wr_data = 32'h00AB_C002;
        lk_valid = 1'b1; lk_vaddr = 32'h0F0F_0123; lk_store = 1'b0;
        @(negedge clk);
        sw_wr_en = 1'b0; lk_valid = 1'b0; cur_asid = 6'd2;
        check("R7 sw beats capture", entryhi_q, 32'h00AB_C002);
        check("R6 badvaddr still captured", badvaddr_q, 32'h0F0F_0123);

        // R8 cmd_valid held while busy is ignored
        sw_wr(2'd2, 32'd1);
        cmd_valid = 1'b1; cmd_op = 2'd0;
        @(negedge clk);
        check("R8 accept", {31'b0, cmd_busy}, 32'd1);
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R8 done while valid", {31'b0, cmd_done}, 32'd1);
        @(negedge clk);
        check("R8 no restart", {31'b0, cmd_busy}, 32'd0);
        check("R9 read via held valid", entryhi_q, hi_word(m_vpn[1], m_asid[1]));

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule